// File: doc/BRIEF.md
# Modulo-63 Residue Generator

This block computes the remainder of a wide unsigned operand divided by 63. A checker uses it to form a residue code of a datapath result, such as a mantissa product or a fused multiply-add sum, and compares that code with one predicted along a separate path. Because 63 is 2^6 − 1, any 6-bit group of the operand has weight 1 modulo 63. The operand is therefore cut into 6-bit slices, and all the slices are summed modulo 63.

The slices go through a parallel tree of 4:2 compressors. Inside the compressors, every carry that leaves the top bit of a slice re-enters at bit 0 of the same slice width. The tree therefore never widens and needs no carry-correction stage at any level. Each level turns groups of four vectors into two. A group of three is filled out with a zero vector, and one or two leftover vectors pass straight to the next level. The last two vectors are added by a 6-bit end-around-carry adder, and a sum of all ones is folded to zero. An optional register between the tree and the final adder sets the latency to one cycle, and the valid flag follows the same latency.

Top module: `res63_gen`

## Requirements
- R1: With the default settings, `out_res_o` in the cycle after a cycle with `in_valid_i` high equals the value of `in_data_i` in that cycle modulo 63.
- R2: While `out_valid_o` is high, `out_res_o` is never 63. An operand that is a multiple of 63, such as 102 consecutive ones, gives 0.
- R3: An all-zero operand gives a residue of 0.
- R4: `out_valid_o` repeats `in_valid_i` one clock later when `PIPE` is 1, or in the same cycle when `PIPE` is 0.
- R5: While `rst_ni` is low, `out_valid_o` is low from the first clock edge onward.
- R6: The bits above `IN_W` in the top slice are taken as zero. The 106-bit all-ones operand gives (2^106 − 1) mod 63 = 15.
- R7: An operand with only bit k set gives 2^(k mod 6).
- R8: Operands presented on back-to-back cycles each give their own residue, with no carry-over between them.
- R9: With `PIPE` = 1, a cycle with `in_valid_i` low leaves `out_res_o` unchanged in the next cycle, whatever `in_data_i` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand qualifier |
| in_data_i | input | IN_W | Unsigned operand |
| out_valid_o | output | 1 | Residue qualifier |
| out_res_o | output | 6 | Residue modulo 63, range 0 to 62 |

## Verification
The properties assume that `in_valid_i` and `in_data_i` are known and change only between clock edges. They also assume that `in_valid_i` stays low while reset is held. The bench drives every input on the falling edge and keeps `in_valid_i` low throughout reset. The random operands cover the full `IN_W` range, so the properties that compare against a plain `%` are exercised with arbitrary bit patterns. The directed cases include zero, all ones, multiples of 63, and every single-bit position.

// File: rtl/res63_pkg.sv
package res63_pkg;

    localparam int unsigned SW = 6;
    localparam logic [SW-1:0] ALL_ONES = {SW{1'b1}};

    typedef logic [SW-1:0] slice_t;

    typedef struct packed {
        logic   vld;
        slice_t va;
        slice_t vb;
    } fin_t;

    // groups of four formed from n vectors; a group of three is zero-filled
    function automatic int unsigned grp_cnt(input int unsigned n);
        int unsigned g;
        g = n / 4;
        if ((n % 4) == 3) g = g + 1;
        return g;
    endfunction

    function automatic int unsigned rem_cnt(input int unsigned n);
        return ((n % 4) == 3) ? 0 : (n % 4);
    endfunction

    function automatic int unsigned next_cnt(input int unsigned n);
        return 2 * grp_cnt(n) + rem_cnt(n);
    endfunction

    function automatic int unsigned cnt_at(input int unsigned n0, input int unsigned lv);
        int unsigned n;
        n = n0;
        for (int unsigned i = 0; i < lv; i++) n = next_cnt(n);
        return n;
    endfunction

    function automatic int unsigned num_lvls(input int unsigned n0);
        int unsigned n;
        int unsigned lv;
        n  = n0;
        lv = 0;
        for (int i = 0; i < 64; i++) begin
            if (n > 2) begin
                n  = next_cnt(n);
                lv = lv + 1;
            end
        end
        return lv;
    endfunction

endpackage

// File: rtl/res63_csa32.sv
module res63_csa32 #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cy_o
);
    logic [W-1:0] maj;

    assign sum_o = x_i ^ y_i ^ z_i;
    assign maj   = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
    // carry weight 2^W is congruent to 1: rotate the top carry into bit 0
    assign cy_o  = {maj[W-2:0], maj[W-1]};
endmodule

// File: rtl/res63_cmp42.sv
module res63_cmp42
    import res63_pkg::*;
(
    input  slice_t a_i,
    input  slice_t b_i,
    input  slice_t c_i,
    input  slice_t d_i,
    output slice_t s_o,
    output slice_t c_o
);
    slice_t s1;
    slice_t c1;

    res63_csa32 #(.W(SW)) u_first (
        .x_i  (a_i),
        .y_i  (b_i),
        .z_i  (c_i),
        .sum_o(s1),
        .cy_o (c1)
    );

    res63_csa32 #(.W(SW)) u_second (
        .x_i  (s1),
        .y_i  (c1),
        .z_i  (d_i),
        .sum_o(s_o),
        .cy_o (c_o)
    );
endmodule

// File: rtl/res63_tree.sv
module res63_tree
    import res63_pkg::*;
#(
    parameter int unsigned IN_W = 106
) (
    input  logic [IN_W-1:0] opnd_i,
    output slice_t          vec_a_o,
    output slice_t          vec_b_o
);
    localparam int unsigned NS    = (IN_W + SW - 1) / SW;
    localparam int unsigned PAD_W = NS * SW;
    localparam int unsigned NLEV  = num_lvls(NS);
    localparam int unsigned NLAST = cnt_at(NS, NLEV);

    logic [PAD_W-1:0] padded;
    assign padded = PAD_W'(opnd_i);

    for (genvar l = 0; l <= NLEV; l++) begin : g_lvl
        localparam int unsigned NCUR = cnt_at(NS, l);
        slice_t row [NCUR];

        if (l == 0) begin : g_src
            for (genvar i = 0; i < NS; i++) begin : g_sl
                assign row[i] = padded[i*SW +: SW];
            end
        end else begin : g_cmp
            localparam int unsigned NPREV = cnt_at(NS, l - 1);
            localparam int unsigned NG    = grp_cnt(NPREV);
            localparam int unsigned NR    = rem_cnt(NPREV);
            slice_t os [2*NG];

            for (genvar g = 0; g < NG; g++) begin : g_grp
                slice_t opd [4];
                for (genvar k = 0; k < 4; k++) begin : g_opd
                    if (4*g + k < NPREV) begin : g_take
                        assign opd[k] = g_lvl[l-1].row[4*g+k];
                    end else begin : g_zero
                        assign opd[k] = '0;
                    end
                end
                res63_cmp42 u_cmp (
                    .a_i(opd[0]),
                    .b_i(opd[1]),
                    .c_i(opd[2]),
                    .d_i(opd[3]),
                    .s_o(os[2*g]),
                    .c_o(os[2*g+1])
                );
            end

            for (genvar i = 0; i < 2*NG; i++) begin : g_cp
                assign row[i] = os[i];
            end
            for (genvar r = 0; r < NR; r++) begin : g_pass
                assign row[2*NG+r] = g_lvl[l-1].row[4*NG+r];
            end
        end
    end

    assign vec_a_o = g_lvl[NLEV].row[0];
    if (NLAST > 1) begin : g_two
        assign vec_b_o = g_lvl[NLEV].row[1];
    end else begin : g_one
        assign vec_b_o = '0;
    end
endmodule

// File: rtl/res63_eac.sv
module res63_eac
    import res63_pkg::*;
(
    input  slice_t a_i,
    input  slice_t b_i,
    output slice_t r_o
);
    logic [SW:0] s;
    slice_t      t;

    assign s   = {1'b0, a_i} + {1'b0, b_i};
    assign t   = s[SW-1:0] + {{(SW-1){1'b0}}, s[SW]};
    assign r_o = (t == ALL_ONES) ? '0 : t;
endmodule

// File: rtl/res63_gen.sv
module res63_gen
    import res63_pkg::*;
#(
    parameter int unsigned IN_W = 106,
    parameter bit          PIPE = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            in_valid_i,
    input  logic [IN_W-1:0] in_data_i,
    output logic            out_valid_o,
    output logic [5:0]      out_res_o
);
    slice_t tv_a;
    slice_t tv_b;
    fin_t   fin_q;

    res63_tree #(.IN_W(IN_W)) u_tree (
        .opnd_i (in_data_i),
        .vec_a_o(tv_a),
        .vec_b_o(tv_b)
    );

    if (PIPE) begin : g_reg
        fin_t fin_d;

        always_comb begin
            fin_d     = fin_q;
            fin_d.vld = in_valid_i;
            if (in_valid_i) begin
                fin_d.va = tv_a;
                fin_d.vb = tv_b;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                fin_q <= '0;
            end else begin
                fin_q <= fin_d;
            end
        end
    end else begin : g_comb
        always_comb begin
            fin_q.vld = in_valid_i;
            fin_q.va  = tv_a;
            fin_q.vb  = tv_b;
        end
    end

    res63_eac u_eac (
        .a_i(fin_q.va),
        .b_i(fin_q.vb),
        .r_o(out_res_o)
    );

    assign out_valid_o = fin_q.vld;
endmodule

// File: rtl/res63_chk.sv
module res63_chk #(
    parameter int unsigned IN_W = 106,
    parameter bit          PIPE = 1'b1
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            in_valid_i,
    input logic [IN_W-1:0] in_data_i,
    input logic            out_valid_o,
    input logic [5:0]      out_res_o
);
    localparam int unsigned MW = (IN_W > 32) ? IN_W : 32;

    a_r2_never_63: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> (out_res_o != 6'd63));

    if (PIPE) begin : g_seq
        a_r1_mod_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
            in_valid_i |=> (MW'(out_res_o) == (MW'($past(in_data_i)) % MW'(63))));

        a_r3_zero_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (in_valid_i && (in_data_i == '0)) |=> (out_res_o == 6'd0));

        a_r4_valid_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
            in_valid_i |=> out_valid_o);

        a_r4_valid_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !in_valid_i |=> !out_valid_o);

        a_r5_reset_clear: assert property (@(posedge clk_i)
            !rst_ni |=> !out_valid_o);

        a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !in_valid_i |=> $stable(out_res_o));
    end else begin : g_cmb
        a_r4_valid_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
            out_valid_o == in_valid_i);
    end
endmodule

bind res63_gen res63_chk #(.IN_W(IN_W), .PIPE(PIPE)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .out_valid_o(out_valid_o),
    .out_res_o  (out_res_o)
);

// File: tb/test_res63_gen.sv
module test_res63_gen;
    localparam int unsigned IN_W = 106;

    logic            clk_i = 1'b0;
    logic            rst_ni;
    logic            in_valid_i;
    logic [IN_W-1:0] in_data_i;
    logic            out_valid_o;
    logic [5:0]      out_res_o;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;
    logic [5:0]  last_exp = '0;

    always #4 clk_i = ~clk_i;

    res63_gen #(.IN_W(IN_W), .PIPE(1'b1)) i_res63_gen (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .in_valid_i (in_valid_i),
        .in_data_i  (in_data_i),
        .out_valid_o(out_valid_o),
        .out_res_o  (out_res_o)
    );

    function automatic logic [5:0] ref_mod(input logic [IN_W-1:0] x);
        logic [IN_W-1:0] r;
        r = x % IN_W'(63);
        return r[5:0];
    endfunction

    function automatic logic [IN_W-1:0] rnd_word();
        logic [127:0] w;
        w = {$urandom(), $urandom(), $urandom(), $urandom()};
        return w[IN_W-1:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input string req, input logic [IN_W-1:0] d);
        in_valid_i = 1'b1;
        in_data_i  = d;
        @(negedge clk_i);
        last_exp = ref_mod(d);
        chk(req, 32'(out_res_o), 32'(last_exp));
        chk("R4", 32'(out_valid_o), 32'd1);
        chk("R2", 32'(out_res_o == 6'd63), 32'd0);
    endtask

    task automatic idle();
        in_valid_i = 1'b0;
        in_data_i  = rnd_word();
        @(negedge clk_i);
        chk("R4", 32'(out_valid_o), 32'd0);
        chk("R9", 32'(out_res_o), 32'(last_exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed_v;
        logic [IN_W-1:0] d;
        seed_v = $urandom(32'd20231103);
        rst_ni     = 1'b0;
        in_valid_i = 1'b0;
        in_data_i  = '0;
        repeat (3) @(negedge clk_i);
        chk("R5", 32'(out_valid_o), 32'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R5", 32'(out_valid_o), 32'd0);

        // R3 zero operand
        send("R3", '0);
        chk("R3", 32'(out_res_o), 32'd0);

        // R6 all ones over the full width, top slice padded
        send("R6", '1);
        chk("R6", 32'(out_res_o), 32'd15);

        // R2 multiple of 63: 102 ones
        d = '0;
        for (int i = 0; i < 102; i++) d[i] = 1'b1;
        send("R2", d);
        chk("R2", 32'(out_res_o), 32'd0);

        // R2 literal 63 and 126
        send("R2", IN_W'(63));
        send("R2", IN_W'(126));

        // R7 every single-bit position
        for (int k = 0; k < IN_W; k++) begin
            d = '0;
            d[k] = 1'b1;
            send("R7", d);
            chk("R7", 32'(out_res_o), 32'(1 << (k % 6)));
        end

        // R9 hold while idle, R4 valid drop
        idle();
        idle();

        // R8 back-to-back random operands, R1 residue
        for (int n = 0; n < 400; n++) begin
            send("R8", rnd_word());
        end

        // R1 mixed random with idle gaps and dense patterns
        for (int n = 0; n < 300; n++) begin
            d = rnd_word();
            if (n % 3 == 0) d = d | (d << 1) | (d << 2);
            send("R1", d);
            if (n % 7 == 0) idle();
        end

        finish_run();
    end
endmodule